// File: doc/BRIEF.md
# Low-Power Sleep Sequencer

This block governs a memory's power-saving sleep state. A sleep request arrives asynchronously to the clock. It is first passed through a flop synchronizer. A sequencer then walks through a fixed entry phase, a resting phase, a fixed exit phase and an enforced recovery window before normal service resumes. The storage itself is never touched, so its contents survive.

Whenever the sequencer is outside its normal awake state, it tells the neighbouring access controller two things: start no access, and keep the data pins floating. A separate guard watches the chip-enable and address-strobe inputs. It flags a protocol violation when a fully enabled strobe arrives while the sequencer is busy. That covers entering, sleeping, exiting and recovering.

Top module: `sleep_seq`

## Requirements
- R1: After synchronous reset, `block_access`, `force_hiz`, `sleeping` and `proto_err` are all 0, and the sequencer is awake.
- R2: A change on `sleep_req` passes through two synchronizing flops. When `sleep_req` is first sampled high at a clock edge, `block_access` stays 0 after the second edge and rises after the third edge.
- R3: Entry lasts exactly two cycles. During these, `block_access` and `force_hiz` are 1 while `sleeping` is 0. `sleeping` rises two cycles after `block_access` rises.
- R4: When `sleep_req` is first sampled low while asleep, `sleeping` falls after the third edge. Two exit cycles and then two recovery cycles follow. `block_access` falls after the seventh edge.
- R5: `block_access` and `force_hiz` are 1 in every state other than awake, including the exit and recovery windows.
- R6: `proto_err` is 1 for the cycle after any edge at which the sequencer was not awake while all `ce_act` bits and at least one `strobe_act` bit were 1. It returns to 0 once the offending inputs clear.
- R7: `proto_err` stays 0 in two cases: when any `ce_act` bit is 0, and when the sequencer was awake at the sampling edge, even if that edge starts entry.
- R8: Entry is never aborted. If the request drops during entry, the sequencer still reaches sleep, holds `sleeping` for one cycle, and then exits.
- R9: A request that is raised again during recovery does not shorten it. The sequencer returns to awake for exactly one cycle (`block_access` 0), then starts a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| ce_act | input | NUM_CE | Chip enables, each normalized to active high |
| strobe_act | input | NUM_STB | Address strobes, normalized to active high |
| block_access | output | 1 | Access controller must start no access |
| force_hiz | output | 1 | Data pins must float |
| sleeping | output | 1 | Sequencer is resting in sleep |
| proto_err | output | 1 | Strobe with all enables seen while not awake |

## Verification
Two functions can fall in the same cycle: the synchronized request starting entry, and an access strobe with all enables active. The bench holds a fully enabled strobe across the edge where the sequencer leaves the awake state. The error flag must stay 0 for that edge and rise for the next one. A second collision is checked as well: the request is raised again in the middle of recovery. There, the one-cycle awake gap that must appear between recovery and the new entry is measured.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

    typedef enum logic [2:0] {
        PS_AWAKE  = 3'd0,
        PS_ENTER  = 3'd1,
        PS_DOZE   = 3'd2,
        PS_WAKE   = 3'd3,
        PS_SETTLE = 3'd4
    } pwr_state_t;

    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_ENTER_CYC   = 2;
    localparam int unsigned DEF_EXIT_CYC    = 2;
    localparam int unsigned DEF_SETTLE_CYC  = 2;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic is_busy(pwr_state_t s);
        return s != PS_AWAKE;
    endfunction

endpackage

// File: rtl/sleep_req_sync.sv
module sleep_req_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import sleep_seq_pkg::*;
#(
    parameter int unsigned ENTER_CYC  = DEF_ENTER_CYC,
    parameter int unsigned EXIT_CYC   = DEF_EXIT_CYC,
    parameter int unsigned SETTLE_CYC = DEF_SETTLE_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic req_s,
    output logic block_access,
    output logic force_hiz,
    output logic sleeping
);
    localparam int unsigned MAXC = max3(ENTER_CYC, EXIT_CYC, SETTLE_CYC);
    localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CW-1:0] LD_ENTER  = CW'(ENTER_CYC - 1);
    localparam logic [CW-1:0] LD_EXIT   = CW'(EXIT_CYC - 1);
    localparam logic [CW-1:0] LD_SETTLE = CW'(SETTLE_CYC - 1);

    pwr_state_t    state;
    logic [CW-1:0] dwell;
    logic          dwell_done;

    assign dwell_done = (dwell == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_AWAKE;
            dwell <= '0;
        end else begin
            case (state)
                PS_AWAKE: if (req_s) begin
                    state <= PS_ENTER;
                    dwell <= LD_ENTER;
                end
                PS_ENTER: begin
                    if (dwell_done) state <= PS_DOZE;
                    else            dwell <= dwell - 1'b1;
                end
                PS_DOZE: if (!req_s) begin
                    state <= PS_WAKE;
                    dwell <= LD_EXIT;
                end
                PS_WAKE: begin
                    if (dwell_done) begin
                        state <= PS_SETTLE;
                        dwell <= LD_SETTLE;
                    end else begin
                        dwell <= dwell - 1'b1;
                    end
                end
                PS_SETTLE: begin
                    if (dwell_done) state <= PS_AWAKE;
                    else            dwell <= dwell - 1'b1;
                end
                default: state <= PS_AWAKE;
            endcase
        end
    end

    assign block_access = is_busy(state);
    assign force_hiz    = is_busy(state);
    assign sleeping     = (state == PS_DOZE);

    // R3
    doze_from_enter_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sleeping) |-> $past(state) == PS_ENTER);

    // R4
    release_from_settle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(block_access) |-> $past(state) == PS_SETTLE);

    // R5
    sleep_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        sleeping |-> (block_access && force_hiz));

    // R8
    enter_runs_out_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ENTER) |=> (state == PS_ENTER || state == PS_DOZE));
endmodule

// File: rtl/sleep_guard.sv
module sleep_guard #(
    parameter int unsigned NUM_CE  = 3,
    parameter int unsigned NUM_STB = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               busy,
    input  logic [NUM_CE-1:0]  ce_act,
    input  logic [NUM_STB-1:0] strobe_act,
    output logic               proto_err
);
    logic hit;
    assign hit = (&ce_act) && (|strobe_act);

    always_ff @(posedge clk) begin
        if (rst) proto_err <= 1'b0;
        else     proto_err <= busy && hit;
    end

    // R7
    partial_enable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(&ce_act) |=> !proto_err);
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
    import sleep_seq_pkg::*;
#(
    parameter int unsigned NUM_CE      = 3,
    parameter int unsigned NUM_STB     = 2,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned ENTER_CYC   = DEF_ENTER_CYC,
    parameter int unsigned EXIT_CYC    = DEF_EXIT_CYC,
    parameter int unsigned SETTLE_CYC  = DEF_SETTLE_CYC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_req,
    input  logic [NUM_CE-1:0]  ce_act,
    input  logic [NUM_STB-1:0] strobe_act,
    output logic               block_access,
    output logic               force_hiz,
    output logic               sleeping,
    output logic               proto_err
);
    logic req_s;

    sleep_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sleep_req),
        .sync_out (req_s)
    );

    sleep_fsm #(
        .ENTER_CYC  (ENTER_CYC),
        .EXIT_CYC   (EXIT_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req_s        (req_s),
        .block_access (block_access),
        .force_hiz    (force_hiz),
        .sleeping     (sleeping)
    );

    sleep_guard #(.NUM_CE(NUM_CE), .NUM_STB(NUM_STB)) u_guard (
        .clk        (clk),
        .rst        (rst),
        .busy       (block_access),
        .ce_act     (ce_act),
        .strobe_act (strobe_act),
        .proto_err  (proto_err)
    );

    // R2
    entry_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(block_access) |-> $past(req_s));

    // R6
    err_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> $past(block_access));
endmodule

// File: tb/test_sleep_seq.sv
module test_sleep_seq;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       sleep_req;
    logic [2:0] ce_act;
    logic [1:0] strobe_act;
    logic       block_access, force_hiz, sleeping, proto_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_seq i_sleep_seq (
        .clk(clk), .rst(rst), .sleep_req(sleep_req),
        .ce_act(ce_act), .strobe_act(strobe_act),
        .block_access(block_access), .force_hiz(force_hiz),
        .sleeping(sleeping), .proto_err(proto_err)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic nclk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic go_awake();
        sleep_req = 1'b0;
        for (int i = 0; i < 40 && block_access; i++) @(negedge clk);
        nclk(1);
    endtask

    task automatic t_reset();
        rst = 1'b1; sleep_req = 1'b0; ce_act = '0; strobe_act = '0;
        nclk(3);
        rst = 1'b0;
        nclk(1);
        chk("R1", "block_access", block_access, 1'b0);
        chk("R1", "force_hiz", force_hiz, 1'b0);
        chk("R1", "sleeping", sleeping, 1'b0);
        chk("R1", "proto_err", proto_err, 1'b0);
    endtask

    task automatic t_enter_exit();
        sleep_req = 1'b1;
        nclk(2);
        chk("R2", "block after 2 edges", block_access, 1'b0);
        nclk(1);
        chk("R2", "block after 3 edges", block_access, 1'b1);
        chk("R3", "sleeping in entry 1", sleeping, 1'b0);
        chk("R5", "hiz in entry", force_hiz, 1'b1);
        nclk(1);
        chk("R3", "sleeping in entry 2", sleeping, 1'b0);
        nclk(1);
        chk("R3", "sleeping after entry", sleeping, 1'b1);
        nclk(3);
        chk("R3", "sleep held", sleeping, 1'b1);
        sleep_req = 1'b0;
        nclk(2);
        chk("R4", "sleeping after 2 edges", sleeping, 1'b1);
        nclk(1);
        chk("R4", "sleeping after 3 edges", sleeping, 1'b0);
        chk("R5", "block in exit", block_access, 1'b1);
        nclk(2);
        chk("R5", "hiz in recovery", force_hiz, 1'b1);
        nclk(1);
        chk("R4", "block after 6 edges", block_access, 1'b1);
        nclk(1);
        chk("R4", "block after 7 edges", block_access, 1'b0);
        chk("R4", "hiz released", force_hiz, 1'b0);
    endtask

    task automatic t_errors();
        sleep_req = 1'b1;
        nclk(6);
        chk("R3", "asleep for error test", sleeping, 1'b1);
        ce_act = 3'b111; strobe_act = 2'b01;
        nclk(1);
        chk("R6", "err on strobe while asleep", proto_err, 1'b1);
        ce_act = '0; strobe_act = '0;
        nclk(1);
        chk("R6", "err clears", proto_err, 1'b0);
        ce_act = 3'b101; strobe_act = 2'b11;
        nclk(1);
        chk("R7", "partial enables", proto_err, 1'b0);
        ce_act = 3'b111; strobe_act = 2'b00;
        nclk(1);
        chk("R7", "no strobe", proto_err, 1'b0);
        sleep_req = 1'b0;
        nclk(5);
        chk("R5", "still recovering", block_access, 1'b1);
        strobe_act = 2'b10;
        nclk(1);
        chk("R6", "err during recovery", proto_err, 1'b1);
        strobe_act = '0; ce_act = '0;
        go_awake();
        ce_act = 3'b111; strobe_act = 2'b10;
        nclk(1);
        chk("R7", "awake access", proto_err, 1'b0);
        ce_act = '0; strobe_act = '0;
    endtask

    task automatic t_collide();
        sleep_req = 1'b1;
        nclk(2);
        ce_act = 3'b111; strobe_act = 2'b01;
        nclk(1);
        chk("R7", "strobe at entry edge", proto_err, 1'b0);
        chk("R2", "entry started", block_access, 1'b1);
        nclk(1);
        chk("R6", "strobe one edge later", proto_err, 1'b1);
        ce_act = '0; strobe_act = '0;
        go_awake();
    endtask

    task automatic t_short_req();
        sleep_req = 1'b1;
        nclk(3);
        chk("R8", "in entry", block_access, 1'b1);
        sleep_req = 1'b0;
        nclk(2);
        chk("R8", "sleep reached", sleeping, 1'b1);
        nclk(1);
        chk("R8", "sleep one cycle", sleeping, 1'b0);
        chk("R8", "exiting", block_access, 1'b1);
        go_awake();
    endtask

    task automatic t_reraise();
        sleep_req = 1'b1;
        nclk(6);
        sleep_req = 1'b0;
        nclk(3);
        chk("R4", "exit begun", sleeping, 1'b0);
        sleep_req = 1'b1;
        nclk(3);
        chk("R9", "recovery not shortened", block_access, 1'b1);
        nclk(1);
        chk("R9", "one awake cycle", block_access, 1'b0);
        nclk(1);
        chk("R9", "re-entry", block_access, 1'b1);
        chk("R9", "re-entry not asleep", sleeping, 1'b0);
        go_awake();
    endtask

    initial begin
        rst = 1'b1; sleep_req = 1'b0; ce_act = '0; strobe_act = '0;
        t_reset();
        t_enter_exit();
        t_errors();
        t_collide();
        t_short_req();
        t_reraise();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule